// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural register state of a 32-bit processor core whose view of its registers depends on the current processor mode. Every mode sees sixteen logical registers, r0 to r15. Some of those slots map to storage private to the mode, and the rest map to storage shared with the unprivileged bank. The five exception modes each also own a saved status register. In total the block holds 37 physical registers: thirty general-purpose words, the program counter, the current status word and five saved status words.

The current mode is taken from the low five bits of the current status word, which is written through its own port. Two combinational read ports and one write port take a 4-bit logical index, and the block resolves that index to physical storage using the mode. Index 15 always selects the program counter. A dedicated port can also load the program counter, for example from the fetch logic. In a privileged mode, a force-user input redirects the general ports to the unprivileged bank. All writes take effect on the rising clock edge, so a read in the same cycle returns the old value.

Top module: `bankrf_top`

## Requirements
- R1: After reset the current status word reads 0x000000D3 (supervisor mode, both interrupt masks set), the program counter reads 0, and every general register and saved status word reads 0.
- R2: User mode (5'b10000) and system mode (5'b11111) resolve all of r0 to r14 to the same storage. A write made in one mode is visible in the other.
- R3: Fast-interrupt mode (5'b10001) has private storage for r8 to r14. Its r0 to r7 are the user copies.
- R4: Normal-interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private r13 and r14 only. Their r0 to r12 are the user copies.
- R5: Index 15 on any port reaches the single program counter in every mode. Stored values have bits [1:0] cleared. When the program-counter port and a general write to index 15 occur in the same cycle, the program-counter port wins.
- R6: Each of the five exception modes reads and writes its own saved status word. In user or system mode, a saved-status read returns 0 and a saved-status write changes no saved status word.
- R7: With force-user set in a privileged mode, reads and writes of r8 to r14 reach the user copies. The saved-status port still addresses the current mode's word.
- R8: A write and a read of the same register in one cycle return the old value on the read. The new value is readable after the clock edge.
- R9: A mode field holding any other encoding behaves as user mode: user bank and no saved status word.
- R10: A write to the current status word becomes visible on its output after the clock edge. A general write in that same cycle uses the mode in force before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpsrWrEn | input | 1 | Load the current status word |
| cpsrWrData | input | 32 | New current status word |
| cpsrOut | output | 32 | Current status word; bits [4:0] are the mode |
| userBankIn | input | 1 | Force general ports to the user bank (privileged modes only) |
| rdAddrA | input | 4 | Logical index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 4 | Logical index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 4 | Logical index for the general write |
| wrData | input | 32 | General write data |
| pcWrEn | input | 1 | Load the program counter directly |
| pcWrData | input | 32 | Program counter load value |
| pcOut | output | 32 | Program counter |
| spsrWrEn | input | 1 | Write the current mode's saved status word |
| spsrWrData | input | 32 | Saved status write data |
| spsrRdData | output | 32 | Current mode's saved status word, or 0 |

## Verification
A wrong mode-to-storage mapping does not show at once. It appears on a read port only when a later access in another mode reaches the slot that was overwritten wrongly, so the bench writes a distinct value into every bank first and reads each back after switching modes. Errors in alignment, program-counter priority and saved-status gating show up on the cycle after the write, through pcOut and spsrRdData. A misplaced write-through bypass shows up in the same cycle as the write, as a new value where the old one is expected.

// File: rtl/bankrf_pkg.sv
`timescale 1ns/1ps
package bankrf_pkg;

  localparam int NUM_GPR   = 30;
  localparam int NUM_SPSR  = 5;
  localparam int GPR_IDX_W = $clog2(NUM_GPR);
  localparam int LOG_IDX_W = 4;
  localparam int FIQ_BASE  = 13;   // first private fast-interrupt slot (its r8)
  localparam int SPLR_BASE = 18;   // first stack/link slot (user r13)

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [GPR_IDX_W-1:0] rdIdxA;
    logic                 rdPcA;
    logic [GPR_IDX_W-1:0] rdIdxB;
    logic                 rdPcB;
    logic                 gprWe;
    logic [GPR_IDX_W-1:0] gprIdx;
    logic                 pcWe;
    logic [NUM_SPSR-1:0]  spsrSel;
  } ctl_t;

  // Slot layout: 0..7 shared low registers, 8..12 user r8-r12,
  // 13..17 fast-interrupt r8-r12, 18..29 r13/r14 pairs per bank.
  function automatic logic [GPR_IDX_W-1:0] mapIdx(input logic [LOG_IDX_W-1:0] idx,
                                                  input bank_e bank);
    int slot;
    if (idx < 4'd8)       slot = int'(idx);
    else if (idx < 4'd13) slot = (bank == BANK_FIQ) ? int'(idx) - 8 + FIQ_BASE : int'(idx);
    else if (idx < 4'd15) slot = SPLR_BASE + 2 * int'(bank) + int'(idx) - 13;
    else                  slot = 0;
    return GPR_IDX_W'(slot);
  endfunction

endpackage

// File: rtl/bankrf_ctrl.sv
`timescale 1ns/1ps
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4:0]           modeBits,
  input  logic                 userBankIn,
  input  logic [LOG_IDX_W-1:0] rdAddrA,
  input  logic [LOG_IDX_W-1:0] rdAddrB,
  input  logic                 wrEn,
  input  logic [LOG_IDX_W-1:0] wrAddr,
  output ctl_t                 ctl
);

  localparam logic [LOG_IDX_W-1:0] PC_IDX = LOG_IDX_W'(15);

  bank_e               modeBank;
  bank_e               gprBank;
  logic                privileged;
  logic [NUM_SPSR-1:0] spsrOneHot;

  always_comb begin
    modeBank   = BANK_USR;
    privileged = 1'b0;
    spsrOneHot = '0;
    case (modeBits)
      MODE_FIQ: begin modeBank = BANK_FIQ; privileged = 1'b1; spsrOneHot[0] = 1'b1; end
      MODE_IRQ: begin modeBank = BANK_IRQ; privileged = 1'b1; spsrOneHot[1] = 1'b1; end
      MODE_SVC: begin modeBank = BANK_SVC; privileged = 1'b1; spsrOneHot[2] = 1'b1; end
      MODE_ABT: begin modeBank = BANK_ABT; privileged = 1'b1; spsrOneHot[3] = 1'b1; end
      MODE_UND: begin modeBank = BANK_UND; privileged = 1'b1; spsrOneHot[4] = 1'b1; end
      MODE_SYS: begin modeBank = BANK_USR; privileged = 1'b1; end
      default:  begin modeBank = BANK_USR; privileged = 1'b0; end
    endcase
  end

  always_comb begin
    gprBank = (userBankIn && privileged) ? BANK_USR : modeBank;
    ctl.rdPcA   = (rdAddrA == PC_IDX);
    ctl.rdPcB   = (rdAddrB == PC_IDX);
    ctl.rdIdxA  = mapIdx(rdAddrA, gprBank);
    ctl.rdIdxB  = mapIdx(rdAddrB, gprBank);
    ctl.gprWe   = wrEn && (wrAddr != PC_IDX);
    ctl.pcWe    = wrEn && (wrAddr == PC_IDX);
    ctl.gprIdx  = mapIdx(wrAddr, gprBank);
    ctl.spsrSel = spsrOneHot;
  end

  AST_FIQ_R8_PRIVATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == MODE_FIQ && !userBankIn && rdAddrA == 4'd8) |-> (ctl.rdIdxA != GPR_IDX_W'(8))); // R3
  AST_FORCE_USER_SP: assert property (@(posedge clk) disable iff (!rstN)
    (userBankIn && modeBits == MODE_SVC && rdAddrA == 4'd13) |-> (ctl.rdIdxA == GPR_IDX_W'(SPLR_BASE))); // R7
  AST_SPSR_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.spsrSel)); // R6

endmodule

// File: rtl/bankrf_data.sv
`timescale 1ns/1ps
module bankrf_data
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CPSR_RESET = DATA_W'(32'h0000_00D3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcWrEn,
  input  logic [DATA_W-1:0] pcWrData,
  input  logic              cpsrWrEn,
  input  logic [DATA_W-1:0] cpsrWrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] cpsrOut,
  output logic [DATA_W-1:0] spsrRdData
);

  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(3);

  logic [NUM_GPR-1:0][DATA_W-1:0]  gpr;
  logic [NUM_SPSR-1:0][DATA_W-1:0] spsr;
  logic [DATA_W-1:0]               pcReg;
  logic [DATA_W-1:0]               cpsrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpr <= '0;
    end else if (ctl.gprWe) begin
      for (int i = 0; i < NUM_GPR; i++) begin
        if (ctl.gprIdx == GPR_IDX_W'(i)) gpr[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spsr <= '0;
    end else if (spsrWrEn) begin
      for (int s = 0; s < NUM_SPSR; s++) begin
        if (ctl.spsrSel[s]) spsr[s] <= spsrWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pcReg <= '0;
    else if (pcWrEn)     pcReg <= pcWrData & ALIGN_MASK;
    else if (ctl.pcWe)   pcReg <= wrData & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cpsrReg <= CPSR_RESET;
    else if (cpsrWrEn) cpsrReg <= cpsrWrData;
  end

  function automatic logic [DATA_W-1:0] pickGpr(input logic [GPR_IDX_W-1:0] idx,
                                                input logic [NUM_GPR-1:0][DATA_W-1:0] bankIn);
    logic [DATA_W-1:0] val;
    val = '0;
    for (int i = 0; i < NUM_GPR; i++) begin
      if (idx == GPR_IDX_W'(i)) val = bankIn[i];
    end
    return val;
  endfunction

  always_comb begin
    rdDataA    = ctl.rdPcA ? pcReg : pickGpr(ctl.rdIdxA, gpr);
    rdDataB    = ctl.rdPcB ? pcReg : pickGpr(ctl.rdIdxB, gpr);
    spsrRdData = '0;
    for (int s = 0; s < NUM_SPSR; s++) begin
      if (ctl.spsrSel[s]) spsrRdData = spsrRdData | spsr[s];
    end
  end

  assign pcOut   = pcReg;
  assign cpsrOut = cpsrReg;

  AST_GPR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gprWe |=> (gpr[$past(ctl.gprIdx)] == $past(wrData))); // R8
  AST_PC_PORT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    pcWrEn |=> (pcOut == ($past(pcWrData) & ALIGN_MASK))); // R5
  AST_SPSR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (spsrWrEn && ctl.spsrSel == '0) |=> $stable(spsr)); // R6
  AST_CPSR_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    cpsrWrEn |=> (cpsrOut == $past(cpsrWrData))); // R10

endmodule

// File: rtl/bankrf_top.sv
`timescale 1ns/1ps
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpsrWrEn,
  input  logic [DATA_W-1:0] cpsrWrData,
  output logic [DATA_W-1:0] cpsrOut,
  input  logic              userBankIn,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcWrEn,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] pcOut,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrRdData
);

  ctl_t       ctl;
  logic [4:0] modeBits;

  assign modeBits = cpsrOut[4:0];

  bankrf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeBits   (modeBits),
    .userBankIn (userBankIn),
    .rdAddrA    (rdAddrA),
    .rdAddrB    (rdAddrB),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .ctl        (ctl)
  );

  bankrf_data #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrData     (wrData),
    .pcWrEn     (pcWrEn),
    .pcWrData   (pcWrData),
    .cpsrWrEn   (cpsrWrEn),
    .cpsrWrData (cpsrWrData),
    .spsrWrEn   (spsrWrEn),
    .spsrWrData (spsrWrData),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .pcOut      (pcOut),
    .cpsrOut    (cpsrOut),
    .spsrRdData (spsrRdData)
  );

  AST_USER_NO_SPSR: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == MODE_USR || modeBits == MODE_SYS) |-> (spsrRdData == '0)); // R6
  AST_UNKNOWN_MODE_NO_SPSR: assert property (@(posedge clk) disable iff (!rstN)
    !(modeBits inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND}) |-> (spsrRdData == '0)); // R9

endmodule

// File: tb/bankrf_top_bench.sv
`timescale 1ns/1ps
module bankrf_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpsrWrEn = 1'b0;
  logic [31:0] cpsrWrData = '0;
  logic [31:0] cpsrOut;
  logic        userBankIn = 1'b0;
  logic [3:0]  rdAddrA = '0;
  logic [31:0] rdDataA;
  logic [3:0]  rdAddrB = '0;
  logic [31:0] rdDataB;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pcWrEn = 1'b0;
  logic [31:0] pcWrData = '0;
  logic [31:0] pcOut;
  logic        spsrWrEn = 1'b0;
  logic [31:0] spsrWrData = '0;
  logic [31:0] spsrRdData;

  int total = 0;
  int bad   = 0;

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b10100;

  logic [4:0] excModes [5];
  logic [4:0] privSlow [4];

  always #5 clk = ~clk;

  bankrf_top u_bankrf_top (
    .clk(clk), .rstN(rstN), .cpsrWrEn(cpsrWrEn), .cpsrWrData(cpsrWrData), .cpsrOut(cpsrOut),
    .userBankIn(userBankIn), .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB),
    .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pcWrEn(pcWrEn),
    .pcWrData(pcWrData), .pcOut(pcOut), .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
    .spsrRdData(spsrRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(input logic [4:0] m);
    cpsrWrEn = 1'b1; cpsrWrData = {24'h0, 3'b110, m};
    tick();
    cpsrWrEn = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] val);
    wrEn = 1'b1; wrAddr = idx; wrData = val;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] val);
    rdAddrA = idx; #1; val = rdDataA;
  endtask

  task automatic wrSpsr(input logic [31:0] val);
    spsrWrEn = 1'b1; spsrWrData = val;
    tick();
    spsrWrEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk("R1 cpsr", cpsrOut, 32'h0000_00D3);
    chk("R1 pc", pcOut, 32'h0);
    rd(4'd0, v);  chk("R1 r0", v, 32'h0);
    rd(4'd13, v); chk("R1 svc r13", v, 32'h0);
    chk("R1 spsr", spsrRdData, 32'h0);
  endtask

  task automatic t_userSystem();
    logic [31:0] v;
    setMode(M_USR); wr(4'd13, 32'h1111_0013);
    setMode(M_SYS); rd(4'd13, v); chk("R2 sys sees usr r13", v, 32'h1111_0013);
    wr(4'd14, 32'h2222_0014);
    setMode(M_USR); rd(4'd14, v); chk("R2 usr sees sys r14", v, 32'h2222_0014);
  endtask

  task automatic t_fiq();
    logic [31:0] v;
    setMode(M_USR);
    for (int i = 0; i < 15; i++) wr(4'(i), 32'h100 + i);
    setMode(M_FIQ);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'h200 + i);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v); chk("R3 fiq low shared", v, 32'h100 + i);
    end
    for (int i = 8; i < 15; i++) begin
      rd(4'(i), v); chk("R3 fiq private", v, 32'h200 + i);
    end
    setMode(M_USR);
    for (int i = 8; i < 15; i++) begin
      rd(4'(i), v); chk("R3 usr untouched", v, 32'h100 + i);
    end
  endtask

  task automatic t_others();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      setMode(privSlow[k]);
      wr(4'd13, 32'h300 + 16 * k);
      wr(4'd14, 32'h301 + 16 * k);
      rd(4'd12, v); chk("R4 r12 shared", v, 32'h10C);
      rd(4'd8, v);  chk("R4 r8 shared", v, 32'h108);
    end
    for (int k = 0; k < 4; k++) begin
      setMode(privSlow[k]);
      rd(4'd13, v); chk("R4 private r13", v, 32'h300 + 16 * k);
      rd(4'd14, v); chk("R4 private r14", v, 32'h301 + 16 * k);
    end
    setMode(M_USR);
    rd(4'd13, v); chk("R4 usr r13 kept", v, 32'h10D);
  endtask

  task automatic t_pc();
    logic [31:0] v;
    setMode(M_FIQ);
    wr(4'd15, 32'h0000_1235);
    chk("R5 aligned write", pcOut, 32'h0000_1234);
    setMode(M_IRQ);
    rd(4'd15, v); chk("R5 r15 shared A", v, 32'h0000_1234);
    rdAddrB = 4'd15; #1; chk("R5 r15 shared B", rdDataB, 32'h0000_1234);
    pcWrEn = 1'b1; pcWrData = 32'h0000_ABCD;
    wrEn = 1'b1; wrAddr = 4'd15; wrData = 32'h0000_5555;
    tick();
    pcWrEn = 1'b0; wrEn = 1'b0;
    #1; chk("R5 pc port priority", pcOut, 32'h0000_ABCC);
  endtask

  task automatic t_spsr();
    for (int k = 0; k < 5; k++) begin
      setMode(excModes[k]); wrSpsr(32'h5000_0000 + k);
    end
    for (int k = 0; k < 5; k++) begin
      setMode(excModes[k]); #1; chk("R6 spsr per mode", spsrRdData, 32'h5000_0000 + k);
    end
    setMode(M_USR); wrSpsr(32'hDEAD_0001);
    #1; chk("R6 usr spsr zero", spsrRdData, 32'h0);
    setMode(M_SYS); wrSpsr(32'hDEAD_0002);
    #1; chk("R6 sys spsr zero", spsrRdData, 32'h0);
    for (int k = 0; k < 5; k++) begin
      setMode(excModes[k]); #1; chk("R6 spsr not hit", spsrRdData, 32'h5000_0000 + k);
    end
  endtask

  task automatic t_forceUser();
    logic [31:0] v;
    setMode(M_SVC);
    userBankIn = 1'b1;
    rd(4'd13, v); chk("R7 svc forced r13", v, 32'h10D);
    wr(4'd14, 32'h0000_00AB);
    #1; chk("R7 spsr still svc", spsrRdData, 32'h5000_0002);
    userBankIn = 1'b0;
    rd(4'd14, v); chk("R7 svc r14 kept", v, 32'h311);
    setMode(M_USR);
    rd(4'd14, v); chk("R7 usr r14 written", v, 32'h0000_00AB);
    setMode(M_FIQ);
    userBankIn = 1'b1;
    rd(4'd8, v); chk("R7 fiq forced r8", v, 32'h108);
    userBankIn = 1'b0;
    rd(4'd8, v); chk("R7 fiq own r8", v, 32'h208);
  endtask

  task automatic t_rdw();
    setMode(M_USR);
    wr(4'd5, 32'h0000_0055);
    wrEn = 1'b1; wrAddr = 4'd5; wrData = 32'h0000_DEAD;
    rdAddrA = 4'd5; rdAddrB = 4'd5; #1;
    chk("R8 old on A", rdDataA, 32'h0000_0055);
    chk("R8 old on B", rdDataB, 32'h0000_0055);
    tick();
    wrEn = 1'b0; #1;
    chk("R8 new on A", rdDataA, 32'h0000_DEAD);
    chk("R8 new on B", rdDataB, 32'h0000_DEAD);
  endtask

  task automatic t_badMode();
    logic [31:0] v;
    setMode(M_BAD);
    rd(4'd13, v); chk("R9 user r13", v, 32'h10D);
    #1; chk("R9 spsr zero", spsrRdData, 32'h0);
    wrSpsr(32'hBAD0_0000);
    wr(4'd8, 32'h0000_0888);
    setMode(M_USR);
    rd(4'd8, v); chk("R9 r8 to user", v, 32'h0000_0888);
    setMode(M_SVC); #1;
    chk("R9 svc spsr kept", spsrRdData, 32'h5000_0002);
  endtask

  task automatic t_cpsr();
    logic [31:0] v;
    setMode(M_USR);
    cpsrWrEn = 1'b1; cpsrWrData = {24'h0, 3'b110, M_SVC};
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'h0000_C0DE;
    #1; chk("R10 before edge", cpsrOut, {24'h0, 3'b110, M_USR});
    tick();
    cpsrWrEn = 1'b0; wrEn = 1'b0;
    #1; chk("R10 after edge", cpsrOut, {24'h0, 3'b110, M_SVC});
    rd(4'd13, v); chk("R10 svc r13 kept", v, 32'h310);
    setMode(M_USR);
    rd(4'd13, v); chk("R10 write used old mode", v, 32'h0000_C0DE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    excModes[0] = M_FIQ; excModes[1] = M_IRQ; excModes[2] = M_SVC;
    excModes[3] = M_ABT; excModes[4] = M_UND;
    privSlow[0] = M_IRQ; privSlow[1] = M_SVC; privSlow[2] = M_ABT; privSlow[3] = M_UND;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_userSystem();
    t_fiq();
    t_others();
    t_pc();
    t_spsr();
    t_forceUser();
    t_rdw();
    t_badMode();
    t_cpsr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule